// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by walking a two-level page table held in memory. A request carries the virtual address and the physical location of the page directory. The walker splits the address into a directory index, a table index and a page offset. It reads the directory entry first. If that entry is marked present, it uses the frame number inside it to find the page-table page, and then reads the table entry. If the leaf entry is also present, the result is the leaf frame number joined to the untouched offset. An entry that is not present at either level ends the walk at once with a fault. This lets a directory mark whole regions unmapped, so their table pages never need to be allocated.

Memory is reached through a single word-read port. A request valid/ready handshake issues one read per level, and a response valid returns the entry word. Only one walk is in flight at a time. The state machine has four states. IDLE accepts a request (transition *accept*). READ_PDE issues the directory read and waits for its response. On a present entry it goes to READ_PTE (transition *descend*); on an absent one it goes to DONE (transition *dir_fault*). READ_PTE issues the table read and waits for its response, then goes to DONE (transitions *leaf_hit* and *leaf_fault*). DONE presents the result for one cycle and returns to IDLE (transition *retire*). The widths of the directory index, table index, offset and frame number are parameters. The default virtual address is 30 bits, split 8/10/12.

Top module: `tlw_walker`

## Requirements
- R1: After reset the walker is in IDLE: `req_ready` is 1, and `mem_req_valid` and `res_valid` are 0.
- R2: The first read of a walk goes to address `req_base + 4 * D`. D is the directory index, taken from the top PD_W bits of the virtual address.
- R3: The second read goes to `(F << OFF_W) + 4 * T`. F is the frame number of the directory entry. T is the table index, taken from the PT_W bits just below the directory index.
- R4: An entry word is FRAME_W+1 bits wide. Bit 0 is the present flag (1 means present) and bits FRAME_W:1 hold the frame number.
- R5: When both entries are present, the result has `res_fault` 0 and `res_paddr` equal to the leaf frame number concatenated with the low OFF_W bits of the virtual address.
- R6: An absent directory entry ends the walk after exactly one memory read, with `res_fault` 1 and `res_paddr` 0.
- R7: An absent table entry ends the walk after exactly two memory reads, with `res_fault` 1 and `res_paddr` 0.
- R8: Each level issues exactly one read. `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen, and drops once the read is accepted.
- R9: `req_ready` is high only in IDLE. Once a request is accepted, it stays low until the walk retires.
- R10: `res_valid` is a single-cycle pulse. It is raised in the cycle after the final response is taken, and the walker is back in IDLE in the cycle that follows.
- R11: The directory base is sampled when the request is accepted. Changes to `req_base` during a walk have no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_base | input | PA_W | Physical address of the page directory |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | PA_W | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | FRAME_W+1 | Entry word returned by memory |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 1 | Walk ended on an absent entry |
| res_paddr | output | PA_W | Translated physical address (0 on a fault) |

## Verification
The assertions assume a well-behaved memory. It returns exactly one response for each accepted read, never in the same cycle as the acceptance, and never while no read is outstanding. They also assume that `req_valid` is only raised toward an idle walker. The bench memory model enforces this: it queues a response only after it has seen the handshake at the edge, waits a latency of zero to two extra cycles, and stalls `mem_req_ready` in a rotating pattern. The driver only raises `req_valid` while `req_ready` is high and waits for each result before starting the next walk.

// File: rtl/tlw_pkg.sv
package tlw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_READ_PDE = 2'd1,
        ST_READ_PTE = 2'd2,
        ST_DONE     = 2'd3
    } walk_state_e;

    typedef enum logic {
        LVL_DIR = 1'b0,
        LVL_TBL = 1'b1
    } walk_level_e;

    localparam int ENTRY_BYTES_LOG2 = 2;

endpackage

// File: rtl/tlw_vsplit.sv
module tlw_vsplit #(
    parameter int PD_W  = 8,
    parameter int PT_W  = 10,
    parameter int OFF_W = 12,
    parameter int VA_W  = PD_W + PT_W + OFF_W
) (
    input  logic [VA_W-1:0]  vaddr,
    output logic [PD_W-1:0]  dir_idx,
    output logic [PT_W-1:0]  tbl_idx,
    output logic [OFF_W-1:0] page_off
);
    localparam int TBL_LSB = OFF_W;
    localparam int DIR_LSB = OFF_W + PT_W;

    assign page_off = vaddr[OFF_W-1:0];
    assign tbl_idx  = vaddr[TBL_LSB +: PT_W];
    assign dir_idx  = vaddr[DIR_LSB +: PD_W];
endmodule

// File: rtl/tlw_addr_gen.sv
module tlw_addr_gen
    import tlw_pkg::*;
#(
    parameter int PD_W    = 8,
    parameter int PT_W    = 10,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 20,
    parameter int PA_W    = FRAME_W + OFF_W
) (
    input  walk_level_e        level,
    input  logic [PA_W-1:0]    dir_base,
    input  logic [PD_W-1:0]    dir_idx,
    input  logic [PT_W-1:0]    tbl_idx,
    input  logic [FRAME_W-1:0] tbl_frame,
    output logic [PA_W-1:0]    rd_addr
);
    logic [PA_W-1:0] dir_off;
    logic [PA_W-1:0] tbl_off;
    logic [PA_W-1:0] tbl_page;
    logic [PA_W-1:0] pde_addr;
    logic [PA_W-1:0] pte_addr;

    // Scale each index by the entry size in bytes.
    assign dir_off  = PA_W'(dir_idx) << ENTRY_BYTES_LOG2;
    assign tbl_off  = PA_W'(tbl_idx) << ENTRY_BYTES_LOG2;
    assign tbl_page = {tbl_frame, {OFF_W{1'b0}}};

    assign pde_addr = dir_base + dir_off;
    assign pte_addr = tbl_page + tbl_off;

    always_comb begin
        unique case (level)
            LVL_DIR: rd_addr = pde_addr;
            LVL_TBL: rd_addr = pte_addr;
            default: rd_addr = pde_addr;
        endcase
    end
endmodule

// File: rtl/tlw_entry_dec.sv
module tlw_entry_dec #(
    parameter int FRAME_W = 20,
    parameter int ENT_W   = FRAME_W + 1
) (
    input  logic [ENT_W-1:0]   word,
    output logic               present,
    output logic [FRAME_W-1:0] frame
);
    assign present = word[0];
    assign frame   = word[ENT_W-1:1];
endmodule

// File: rtl/tlw_fsm.sv
module tlw_fsm
    import tlw_pkg::*;
#(
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 20,
    parameter int VA_W    = 30,
    parameter int PA_W    = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [PA_W-1:0]    req_base,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  logic               ent_present,
    input  logic [FRAME_W-1:0] ent_frame,
    input  logic [OFF_W-1:0]   page_off,
    output logic               req_ready,
    output logic               mem_req_valid,
    output walk_level_e        level,
    output logic [VA_W-1:0]    cur_vaddr,
    output logic [PA_W-1:0]    cur_base,
    output logic [FRAME_W-1:0] tbl_frame,
    output logic               res_valid,
    output logic               res_fault,
    output logic [PA_W-1:0]    res_paddr
);
    walk_state_e        state_q, state_d;
    logic               sent_q, sent_d;
    logic [VA_W-1:0]    vaddr_q, vaddr_d;
    logic [PA_W-1:0]    base_q, base_d;
    logic [FRAME_W-1:0] frame_q, frame_d;
    logic [PA_W-1:0]    paddr_q, paddr_d;
    logic               fault_q, fault_d;
    logic               rsp_take;

    assign rsp_take = sent_q && mem_rsp_valid;

    // Next-state and datapath update.
    always_comb begin
        state_d = state_q;
        sent_d  = sent_q;
        vaddr_d = vaddr_q;
        base_d  = base_q;
        frame_d = frame_q;
        paddr_d = paddr_q;
        fault_d = fault_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_READ_PDE;
                    sent_d  = 1'b0;
                    vaddr_d = req_vaddr;
                    base_d  = req_base;
                    paddr_d = '0;
                    fault_d = 1'b0;
                end
            end
            ST_READ_PDE: begin
                if (!sent_q && mem_req_ready) begin
                    sent_d = 1'b1;
                end else if (rsp_take) begin
                    sent_d = 1'b0;
                    if (ent_present) begin
                        frame_d = ent_frame;
                        state_d = ST_READ_PTE;
                    end else begin
                        fault_d = 1'b1;
                        paddr_d = '0;
                        state_d = ST_DONE;
                    end
                end
            end
            ST_READ_PTE: begin
                if (!sent_q && mem_req_ready) begin
                    sent_d = 1'b1;
                end else if (rsp_take) begin
                    sent_d  = 1'b0;
                    state_d = ST_DONE;
                    if (ent_present) begin
                        fault_d = 1'b0;
                        paddr_d = {ent_frame, page_off};
                    end else begin
                        fault_d = 1'b1;
                        paddr_d = '0;
                    end
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sent_q  <= 1'b0;
            vaddr_q <= '0;
            base_q  <= '0;
            frame_q <= '0;
            paddr_q <= '0;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            sent_q  <= sent_d;
            vaddr_q <= vaddr_d;
            base_q  <= base_d;
            frame_q <= frame_d;
            paddr_q <= paddr_d;
            fault_q <= fault_d;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        level         = LVL_DIR;
        res_valid     = 1'b0;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_READ_PDE: mem_req_valid = !sent_q;
            ST_READ_PTE: begin
                mem_req_valid = !sent_q;
                level         = LVL_TBL;
            end
            ST_DONE:     res_valid = 1'b1;
            default:     req_ready = 1'b0;
        endcase
    end

    assign cur_vaddr = vaddr_q;
    assign cur_base  = base_q;
    assign tbl_frame = frame_q;
    assign res_fault = fault_q;
    assign res_paddr = paddr_q;
endmodule

// File: rtl/tlw_walker.sv
module tlw_walker
    import tlw_pkg::*;
#(
    parameter int PD_W    = 8,
    parameter int PT_W    = 10,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 20,
    parameter int VA_W    = PD_W + PT_W + OFF_W,
    parameter int PA_W    = FRAME_W + OFF_W,
    parameter int ENT_W   = FRAME_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PA_W-1:0]  req_base,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [ENT_W-1:0] mem_rsp_data,
    output logic             res_valid,
    output logic             res_fault,
    output logic [PA_W-1:0]  res_paddr
);
    walk_level_e        level;
    logic [VA_W-1:0]    cur_vaddr;
    logic [PA_W-1:0]    cur_base;
    logic [FRAME_W-1:0] tbl_frame;
    logic [PD_W-1:0]    dir_idx;
    logic [PT_W-1:0]    tbl_idx;
    logic [OFF_W-1:0]   page_off;
    logic               ent_present;
    logic [FRAME_W-1:0] ent_frame;

    tlw_vsplit #(
        .PD_W(PD_W), .PT_W(PT_W), .OFF_W(OFF_W), .VA_W(VA_W)
    ) u_split (
        .vaddr(cur_vaddr), .dir_idx(dir_idx), .tbl_idx(tbl_idx), .page_off(page_off)
    );

    tlw_addr_gen #(
        .PD_W(PD_W), .PT_W(PT_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .PA_W(PA_W)
    ) u_addr (
        .level(level), .dir_base(cur_base), .dir_idx(dir_idx), .tbl_idx(tbl_idx),
        .tbl_frame(tbl_frame), .rd_addr(mem_req_addr)
    );

    tlw_entry_dec #(
        .FRAME_W(FRAME_W), .ENT_W(ENT_W)
    ) u_dec (
        .word(mem_rsp_data), .present(ent_present), .frame(ent_frame)
    );

    tlw_fsm #(
        .OFF_W(OFF_W), .FRAME_W(FRAME_W), .VA_W(VA_W), .PA_W(PA_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_base(req_base),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .ent_present(ent_present), .ent_frame(ent_frame), .page_off(page_off),
        .req_ready(req_ready), .mem_req_valid(mem_req_valid), .level(level),
        .cur_vaddr(cur_vaddr), .cur_base(cur_base), .tbl_frame(tbl_frame),
        .res_valid(res_valid), .res_fault(res_fault), .res_paddr(res_paddr)
    );
endmodule

// File: rtl/tlw_walker_chk.sv
module tlw_walker_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            res_valid,
    input logic            res_fault,
    input logic [PA_W-1:0] res_paddr
);
    logic [2:0] acc_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt <= '0;
        end else if (res_valid) begin
            acc_cnt <= '0;
        end else if (mem_req_valid && mem_req_ready && acc_cnt != 3'd7) begin
            acc_cnt <= acc_cnt + 3'd1;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !res_valid)); // R9

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R9

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R8

    AST_READ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R8

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (!res_valid && req_ready)); // R10

    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_paddr == '0)); // R6

    AST_LEAF_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_fault) |-> (acc_cnt == 3'd2)); // R5

    AST_READS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (acc_cnt == 3'd1 || acc_cnt == 3'd2)); // R7
endmodule

bind tlw_walker tlw_walker_chk #(.PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .res_valid(res_valid), .res_fault(res_fault),
    .res_paddr(res_paddr)
);

// File: tb/tlw_walker_bench.sv
module tlw_walker_bench;
    localparam int PD_W = 4, PT_W = 4, OFF_W = 12, FRAME_W = 8;
    localparam int VA_W = 20, PA_W = 20, ENT_W = 9;

    typedef struct {
        logic [PA_W-1:0] pa;
        logic            fault;
        int              n;
        logic [PA_W-1:0] a0;
        logic [PA_W-1:0] a1;
        string           rq;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [VA_W-1:0] req_vaddr = '0;
    logic [PA_W-1:0] req_base = '0;
    logic mem_req_valid;
    logic mem_req_ready = 1'b0;
    logic [PA_W-1:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [ENT_W-1:0] mem_rsp_data = '0;
    logic res_valid;
    logic res_fault;
    logic [PA_W-1:0] res_paddr;

    int total = 0;
    int bad = 0;
    exp_t exp_q[$];
    int rd_n = 0;
    logic [PA_W-1:0] rd_a [2];
    bit done = 0;

    always #2 clk = ~clk;

    tlw_walker #(.PD_W(PD_W), .PT_W(PT_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) u_tlw_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_base(req_base), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_fault(res_fault), .res_paddr(res_paddr)
    );

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Memory image: entries are {frame, present}, R4 format.
    function automatic logic [ENT_W-1:0] mem_word(input logic [PA_W-1:0] a);
        case (a)
            20'h05000: return 9'h061;   // dir A[0] -> table frame 0x30
            20'h0503C: return 9'h125;   // dir A[15] -> table frame 0x92
            20'h07000: return 9'h125;   // dir B[0] -> table frame 0x92
            20'h30000: return 9'h021;   // leaf frame 0x10
            20'h30004: return 9'h047;   // leaf frame 0x23
            20'h30008: return 9'h040;   // frame 0x20 but absent
            20'h92038: return 9'h0AB;   // leaf frame 0x55
            default:   return 9'h000;
        endcase
    endfunction

    task automatic check_result();
        exp_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R10 unexpected result", 32'(res_paddr), 32'h0);
            return;
        end
        e = exp_q.pop_front();
        check(res_paddr == e.pa, {e.rq, " paddr"}, 32'(res_paddr), 32'(e.pa));
        check(res_fault == e.fault, {e.rq, " fault"}, 32'(res_fault), 32'(e.fault));
        check(rd_n == e.n, "R8 read count", 32'(rd_n), 32'(e.n));
        if (rd_n >= 1) check(rd_a[0] == e.a0, "R2 dir addr", 32'(rd_a[0]), 32'(e.a0));
        if (rd_n >= 2) check(rd_a[1] == e.a1, "R3 tbl addr", 32'(rd_a[1]), 32'(e.a1));
        check(!mem_req_valid, "R10 no read with result", 32'(mem_req_valid), 32'h0);
        rd_n = 0;
    endtask

    // Memory responder and result monitor, all at the falling edge.
    initial begin
        int tick = 0;
        bit hs_p = 0;
        logic [PA_W-1:0] hs_a = '0;
        bit pend = 0;
        int cnt = 0;
        logic [PA_W-1:0] pa = '0;
        bit prv_wait = 0;
        logic [PA_W-1:0] prv_addr = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                hs_p = 0; pend = 0; prv_wait = 0;
                mem_rsp_valid = 1'b0; mem_req_ready = 1'b0;
                continue;
            end
            if (prv_wait)
                check(mem_req_valid && mem_req_addr == prv_addr, "R8 hold",
                      32'(mem_req_addr), 32'(prv_addr));
            if (res_valid) check_result();
            if (hs_p) begin
                pend = 1; cnt = tick % 3; pa = hs_a; hs_p = 0;
            end
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_word(pa);
                    pend = 0;
                end else begin
                    cnt--;
                end
            end
            mem_req_ready = (tick % 4) != 1;
            tick++;
            prv_wait = mem_req_valid && !mem_req_ready;
            prv_addr = mem_req_addr;
            if (mem_req_valid && mem_req_ready) begin
                hs_p = 1; hs_a = mem_req_addr;
                if (rd_n < 2) rd_a[rd_n] = mem_req_addr;
                rd_n++;
            end
        end
    end

    task automatic run_walk(input logic [VA_W-1:0] va, input logic [PA_W-1:0] base,
                            input logic [PA_W-1:0] base_after, input logic [PA_W-1:0] pa,
                            input logic f, input int n, input logic [PA_W-1:0] a1,
                            input string rq);
        exp_t e;
        e.pa = pa; e.fault = f; e.n = n; e.rq = rq; e.a1 = a1;
        e.a0 = base + (PA_W'(va[19:16]) << 2);
        exp_q.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_base = base;
        @(negedge clk);
        req_valid = 1'b0; req_base = base_after;
        check(!req_ready, "R9 busy after accept", 32'(req_ready), 32'h0);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'h1);
        check(!mem_req_valid, "R1 mem idle", 32'(mem_req_valid), 32'h0);
        check(!res_valid, "R1 result idle", 32'(res_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after release", 32'(req_ready), 32'h1);
        // R5: both levels present
        run_walk(20'h01ABC, 20'h05000, 20'h05000, 20'h23ABC, 1'b0, 2, 20'h30004, "R5");
        run_walk(20'hFEED0, 20'h05000, 20'h05000, 20'h55ED0, 1'b0, 2, 20'h92038, "R5");
        run_walk(20'h00000, 20'h05000, 20'h05000, 20'h10000, 1'b0, 2, 20'h30000, "R4");
        // R6: absent directory entry
        run_walk(20'h51234, 20'h05000, 20'h05000, 20'h00000, 1'b1, 1, 20'h00000, "R6");
        // R7: absent table entry with a nonzero frame field
        run_walk(20'h02000, 20'h05000, 20'h05000, 20'h00000, 1'b1, 2, 20'h30008, "R7");
        run_walk(20'hF0FFF, 20'h05000, 20'h05000, 20'h00000, 1'b1, 2, 20'h92000, "R7");
        // R11: base changed right after acceptance
        run_walk(20'h0E123, 20'h07000, 20'h05000, 20'h55123, 1'b0, 2, 20'h92038, "R11");
        run_walk(20'h0E123, 20'h05000, 20'h07000, 20'h00000, 1'b1, 2, 20'h30038, "R11");
        for (int k = 0; k < 3; k++)
            run_walk(20'h01000 | 20'(k * 16'h111), 20'h05000, 20'h05000,
                     20'h23000 | 20'(k * 16'h111), 1'b0, 2, 20'h30004, "R5");
        repeat (4) @(negedge clk);
        check(req_ready == 1'b1, "R10 back to idle", 32'(req_ready), 32'h1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule